// File: doc/BRIEF.md
# Pulse-per-second timebase with seconds clock

This block keeps wall-clock time from a single reference clock. A sub-second counter counts reference cycles and wraps once per second. When it wraps, a seconds counter advances and a one-pulse-per-second output is started. The pulse width is set in reference cycles. The current time is also driven out as a timecode word pair (seconds plus cycles) for neighbouring logic.

Software uses a 32-bit word-addressed register bus to control the block. It can clear the time, stop or run the count, load an absolute time, or add a signed-free offset (a forward step) to the running time. It can also arm a one-shot realignment to an external pulse-per-second input. Load and offset values are first written to staging registers and then committed by a command bit. Each of the two outputs has its own software valid flag.

With the default parameters the second length is 125,000,000 cycles, the sub-second counter is 28 bits wide and the seconds counter is 40 bits wide. All three are parameters.

Top module: `pps_rtc`

## Requirements
- R1: Writing the control word (offset 0x00) with bit 0 set clears both counters on the next clock edge. Writing it with bit 0 clear does not touch the counters.
- R2: Control bit 1 enables counting. While it is 0 and no command is pending, both counters hold their value.
- R3: While counting, the sub-second counter steps from CYCLES_PER_SEC-1 to 0, and on that same edge the seconds counter goes up by one, modulo 2^40.
- R4: Writing the control word with bit 3 set loads the counters from the staging registers on the next edge. The staging registers are: sub-second at 0x10, seconds bits 31:0 at 0x14, and seconds bits 39:32 at 0x18.
- R5: Writing the control word with bit 2 set adds the staged values to the counters on the next edge. If the sub-second sum reaches CYCLES_PER_SEC, CYCLES_PER_SEC is subtracted and one is carried into the seconds. The seconds sum wraps modulo 2^40.
- R6: Control bit 2 reads 1 right after the adjust write and reads 0 once the adjustment has been applied one edge later.
- R7: Writing 1 to bit 0 at offset 0x1C arms a sync, and that bit then reads 0 until the sync completes (it reads 1 otherwise). The external input passes through a two-flop synchroniser. On the third clock edge after it rises, the sub-second counter becomes 0, the seconds go up by one, and the bit reads 1 again.
- R8: A rising edge on the external input has no effect while no sync is armed.
- R9: The pulse output rises on the edge where the sub-second counter returns to 0 by wrap or by sync. It stays high for the number of cycles in control bits 31:4. It is driven only while counting is enabled and bit 1 at 0x1C is 1.
- R10: The timecode valid output follows bit 2 at 0x1C. The timecode outputs carry the live counters.
- R11: Reads return the sub-second count at 0x04, seconds bits 31:0 at 0x08 and bits 39:32 at 0x0C. Reads also return the control word (bit 3 reads 0), the staging registers, and the flags at 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| ext_pps_i | input | 1 | External pulse-per-second input, asynchronous |
| pps_o | output | 1 | Generated pulse-per-second |
| tc_sub_o | output | 28 | Timecode sub-second cycle count |
| tc_sec_o | output | 40 | Timecode seconds |
| tc_valid_o | output | 1 | Timecode valid flag |

## Verification
The range check on the sub-second counter only holds if software never stages a sub-second value at or above CYCLES_PER_SEC. The set and adjust paths copy or add that value without clamping it. Every vector and directed test therefore stages sub-second values below the second length. The bench shortens the second to 100 cycles so that wraps, pulses and syncs all fit in a short run. It changes the external input only on falling clock edges, and it raises it only while the sub-second count is far from a wrap. That way a sync never coincides with a wrap or with a software command.

// File: rtl/pps_rtc_pkg.sv
package pps_rtc_pkg;

   localparam int BUS_AW = 5;
   localparam int BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_CTRL    = 5'h00;
   localparam logic [BUS_AW-1:0] OFS_SUB     = 5'h04;
   localparam logic [BUS_AW-1:0] OFS_SEC_LO  = 5'h08;
   localparam logic [BUS_AW-1:0] OFS_SEC_HI  = 5'h0C;
   localparam logic [BUS_AW-1:0] OFS_STG_SUB = 5'h10;
   localparam logic [BUS_AW-1:0] OFS_STG_LO  = 5'h14;
   localparam logic [BUS_AW-1:0] OFS_STG_HI  = 5'h18;
   localparam logic [BUS_AW-1:0] OFS_FLAGS   = 5'h1C;

   // control word bit positions
   localparam int CB_CLEAR  = 0;
   localparam int CB_RUN    = 1;
   localparam int CB_ADJUST = 2;
   localparam int CB_LOAD   = 3;
   localparam int CB_WIDTH  = 4;
   localparam int WIDTH_W   = BUS_DW - CB_WIDTH;

   // flags word bit positions
   localparam int FB_ARM      = 0;
   localparam int FB_PPS_OK   = 1;
   localparam int FB_TIME_OK  = 2;

   typedef struct packed {
      logic clear;
      logic load;
      logic adjust;
   } cmd_t;

endpackage

// File: rtl/pps_rtc_regs.sv
module pps_rtc_regs
   import pps_rtc_pkg::*;
#(
   parameter int SUB_W = 28,
   parameter int SEC_W = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [BUS_AW-1:0]   addr_i,
   input  logic [BUS_DW-1:0]   wdata_i,
   output logic [BUS_DW-1:0]   rdata_o,
   input  logic [SUB_W-1:0]    sub_i,
   input  logic [SEC_W-1:0]    sec_i,
   input  logic                sync_hit_i,
   output logic                run_o,
   output logic [WIDTH_W-1:0]  width_o,
   output cmd_t                cmd_o,
   output logic [SUB_W-1:0]    stg_sub_o,
   output logic [SEC_W-1:0]    stg_sec_o,
   output logic                sync_arm_o,
   output logic                pps_ok_o,
   output logic                time_ok_o
);

   localparam int HI_W = SEC_W - 32;

   logic [31:0]     stg_lo_q;
   logic [HI_W-1:0] stg_hi_q;
   logic            wr_ctrl, wr_flags;

   assign wr_ctrl  = wr_i && (addr_i == OFS_CTRL);
   assign wr_flags = wr_i && (addr_i == OFS_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o      <= '0;
         run_o      <= 1'b0;
         width_o    <= '0;
         stg_sub_o  <= '0;
         stg_lo_q   <= '0;
         stg_hi_q   <= '0;
         sync_arm_o <= 1'b0;
         pps_ok_o   <= 1'b0;
         time_ok_o  <= 1'b0;
      end else begin
         cmd_o.clear  <= wr_ctrl && wdata_i[CB_CLEAR];
         cmd_o.load   <= wr_ctrl && wdata_i[CB_LOAD];
         cmd_o.adjust <= wr_ctrl && wdata_i[CB_ADJUST];
         if (wr_ctrl) begin
            run_o   <= wdata_i[CB_RUN];
            width_o <= wdata_i[BUS_DW-1:CB_WIDTH];
         end
         if (wr_i && addr_i == OFS_STG_SUB) stg_sub_o <= wdata_i[SUB_W-1:0];
         if (wr_i && addr_i == OFS_STG_LO)  stg_lo_q  <= wdata_i;
         if (wr_i && addr_i == OFS_STG_HI)  stg_hi_q  <= wdata_i[HI_W-1:0];
         if (wr_flags) begin
            pps_ok_o  <= wdata_i[FB_PPS_OK];
            time_ok_o <= wdata_i[FB_TIME_OK];
         end
         if (wr_flags && wdata_i[FB_ARM])
            sync_arm_o <= 1'b1;
         else if (sync_hit_i)
            sync_arm_o <= 1'b0;
      end
   end

   assign stg_sec_o = {stg_hi_q, stg_lo_q};

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         OFS_CTRL: begin
            rdata_o[BUS_DW-1:CB_WIDTH] = width_o;
            rdata_o[CB_ADJUST]         = cmd_o.adjust;
            rdata_o[CB_RUN]            = run_o;
         end
         OFS_SUB:     rdata_o[SUB_W-1:0] = sub_i;
         OFS_SEC_LO:  rdata_o            = sec_i[31:0];
         OFS_SEC_HI:  rdata_o[HI_W-1:0]  = sec_i[SEC_W-1:32];
         OFS_STG_SUB: rdata_o[SUB_W-1:0] = stg_sub_o;
         OFS_STG_LO:  rdata_o            = stg_lo_q;
         OFS_STG_HI:  rdata_o[HI_W-1:0]  = stg_hi_q;
         OFS_FLAGS: begin
            rdata_o[FB_ARM]     = !sync_arm_o;
            rdata_o[FB_PPS_OK]  = pps_ok_o;
            rdata_o[FB_TIME_OK] = time_ok_o;
         end
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/pps_rtc_edge_sync.sv
module pps_rtc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pps_rtc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] && !prev_q;

endmodule

// File: rtl/pps_rtc_counter.sv
module pps_rtc_counter
   import pps_rtc_pkg::*;
#(
   parameter int SUB_W          = 28,
   parameter int SEC_W          = 40,
   parameter int CYCLES_PER_SEC = 125_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  cmd_t             cmd_i,
   input  logic [SUB_W-1:0] stg_sub_i,
   input  logic [SEC_W-1:0] stg_sec_i,
   input  logic             sync_arm_i,
   input  logic             ext_rise_i,
   output logic [SUB_W-1:0] sub_o,
   output logic [SEC_W-1:0] sec_o,
   output logic             sync_hit_o,
   output logic             sec_start_o
);

   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(CYCLES_PER_SEC - 1);
   localparam logic [SUB_W:0]   LIM_X    = (SUB_W+1)'(CYCLES_PER_SEC);

   logic             any_cmd;
   logic [SUB_W:0]   sum_x;
   logic             carry;
   logic [SUB_W-1:0] adj_sub;
   logic             tick_wrap;
   logic [SUB_W-1:0] sub_d;
   logic [SEC_W-1:0] sec_d;

   assign any_cmd    = cmd_i.clear || cmd_i.load || cmd_i.adjust;
   assign sync_hit_o = sync_arm_i && ext_rise_i && !any_cmd;
   assign tick_wrap  = run_i && (sub_o == LAST_SUB) && !any_cmd && !sync_hit_o;
   assign sec_start_o = sync_hit_o || tick_wrap;

   assign sum_x   = {1'b0, sub_o} + {1'b0, stg_sub_i};
   assign carry   = (sum_x >= LIM_X);
   assign adj_sub = carry ? SUB_W'(sum_x - LIM_X) : sum_x[SUB_W-1:0];

   always_comb begin
      sub_d = sub_o;
      sec_d = sec_o;
      if (cmd_i.clear) begin
         sub_d = '0;
         sec_d = '0;
      end else if (cmd_i.load) begin
         sub_d = stg_sub_i;
         sec_d = stg_sec_i;
      end else if (cmd_i.adjust) begin
         sub_d = adj_sub;
         sec_d = sec_o + stg_sec_i + SEC_W'(carry);
      end else if (sync_hit_o || tick_wrap) begin
         sub_d = '0;
         sec_d = sec_o + SEC_W'(1);
      end else if (run_i) begin
         sub_d = sub_o + SUB_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_o <= '0;
         sec_o <= '0;
      end else begin
         sub_o <= sub_d;
         sec_o <= sec_d;
      end
   end

endmodule

// File: rtl/pps_rtc_pulse.sv
module pps_rtc_pulse #(
   parameter int WIDTH_W = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [WIDTH_W-1:0] width_i,
   input  logic               gate_i,
   output logic               pulse_o
);

   logic [WIDTH_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (start_i)
         left_q <= width_i;
      else if (left_q != '0)
         left_q <= left_q - WIDTH_W'(1);
   end

   assign pulse_o = gate_i && (left_q != '0);

endmodule

// File: rtl/pps_rtc.sv
module pps_rtc
   import pps_rtc_pkg::*;
#(
   parameter int SUB_W          = 28,
   parameter int SEC_W          = 40,
   parameter int CYCLES_PER_SEC = 125_000_000,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [4:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ext_pps_i,
   output logic              pps_o,
   output logic [SUB_W-1:0]  tc_sub_o,
   output logic [SEC_W-1:0]  tc_sec_o,
   output logic              tc_valid_o
);

   generate
      if (SUB_W < 2 || SUB_W > 28) begin : g_bad_sub_w
         $error("pps_rtc: SUB_W must lie in 2..28");
      end
      if (SEC_W < 33 || SEC_W > 64) begin : g_bad_sec_w
         $error("pps_rtc: SEC_W must lie in 33..64");
      end
      if (CYCLES_PER_SEC < 2 || longint'(CYCLES_PER_SEC) > (longint'(1) << SUB_W)) begin : g_bad_cps
         $error("pps_rtc: CYCLES_PER_SEC must fit the sub-second counter");
      end
   endgenerate

   cmd_t               cmd;
   logic               run;
   logic [WIDTH_W-1:0] width;
   logic [SUB_W-1:0]   stg_sub;
   logic [SEC_W-1:0]   stg_sec;
   logic               sync_arm;
   logic               pps_ok;
   logic               time_ok;
   logic               ext_rise;
   logic               sync_hit;
   logic               sec_start;

   pps_rtc_regs #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .wdata_i    (bus_wdata),
      .rdata_o    (bus_rdata),
      .sub_i      (tc_sub_o),
      .sec_i      (tc_sec_o),
      .sync_hit_i (sync_hit),
      .run_o      (run),
      .width_o    (width),
      .cmd_o      (cmd),
      .stg_sub_o  (stg_sub),
      .stg_sec_o  (stg_sec),
      .sync_arm_o (sync_arm),
      .pps_ok_o   (pps_ok),
      .time_ok_o  (time_ok)
   );

   pps_rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_pps_i),
      .rise_o  (ext_rise)
   );

   pps_rtc_counter #(
      .SUB_W(SUB_W), .SEC_W(SEC_W), .CYCLES_PER_SEC(CYCLES_PER_SEC)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .cmd_i       (cmd),
      .stg_sub_i   (stg_sub),
      .stg_sec_i   (stg_sec),
      .sync_arm_i  (sync_arm),
      .ext_rise_i  (ext_rise),
      .sub_o       (tc_sub_o),
      .sec_o       (tc_sec_o),
      .sync_hit_o  (sync_hit),
      .sec_start_o (sec_start)
   );

   pps_rtc_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sec_start),
      .width_i (width),
      .gate_i  (run && pps_ok),
      .pulse_o (pps_o)
   );

   assign tc_valid_o = time_ok;

endmodule

// File: rtl/pps_rtc_chk.sv
module pps_rtc_chk #(
   parameter int SUB_W          = 28,
   parameter int SEC_W          = 40,
   parameter int CYCLES_PER_SEC = 125_000_000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adj_write,
   input logic             pps_o,
   input logic [SUB_W-1:0] tc_sub,
   input logic [SEC_W-1:0] tc_sec,
   input logic             run,
   input logic             pps_ok,
   input logic             c_clear,
   input logic             c_load,
   input logic             c_adjust,
   input logic             sync_hit,
   input logic [SUB_W-1:0] stg_sub,
   input logic [SEC_W-1:0] stg_sec
);

   localparam logic [SUB_W:0]   LIM_X    = (SUB_W+1)'(CYCLES_PER_SEC);
   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(CYCLES_PER_SEC - 1);

   logic quiet;
   assign quiet = !c_clear && !c_load && !c_adjust && !sync_hit;

   // R3: sub-second count stays inside the second
   a_r3_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, tc_sub} < LIM_X);

   // R1
   a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      c_clear |=> (tc_sub == '0) && (tc_sec == '0));

   // R4
   a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      c_load && !c_clear |=> (tc_sub == $past(stg_sub)) && (tc_sec == $past(stg_sec)));

   // R6
   a_r6_adjust_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      c_adjust && !adj_write |=> !c_adjust);

   // R2
   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run && quiet |=> $stable(tc_sub) && $stable(tc_sec));

   // R3
   a_r3_wrap_carries: assert property (@(posedge clk) disable iff (!rst_n)
      run && quiet && (tc_sub == LAST_SUB)
      |=> (tc_sub == '0) && (tc_sec == SEC_W'($past(tc_sec) + 1'b1)));

   // R7
   a_r7_sync_realigns: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |=> (tc_sub == '0) && (tc_sec == SEC_W'($past(tc_sec) + 1'b1)));

   // R9
   a_r9_rise_at_second: assert property (@(posedge clk) disable iff (!rst_n)
      pps_o && !$past(pps_o) && $past(run && pps_ok) |-> (tc_sub == '0));

endmodule

bind pps_rtc pps_rtc_chk #(
   .SUB_W(SUB_W), .SEC_W(SEC_W), .CYCLES_PER_SEC(CYCLES_PER_SEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adj_write (bus_wr && (bus_addr == 5'h00) && bus_wdata[2]),
   .pps_o     (pps_o),
   .tc_sub    (tc_sub_o),
   .tc_sec    (tc_sec_o),
   .run       (run),
   .pps_ok    (pps_ok),
   .c_clear   (cmd.clear),
   .c_load    (cmd.load),
   .c_adjust  (cmd.adjust),
   .sync_hit  (sync_hit),
   .stg_sub   (stg_sub),
   .stg_sec   (stg_sec)
);

// File: tb/tb_pps_rtc.sv
module tb_pps_rtc;

   localparam int CLK_PERIOD = 8;
   localparam int CPS        = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ext_pps_i = 1'b0;
   logic        pps_o;
   logic [27:0] tc_sub_o;
   logic [39:0] tc_sec_o;
   logic        tc_valid_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pps_rtc #(.CYCLES_PER_SEC(CPS)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pps_i(ext_pps_i),
      .pps_o(pps_o), .tc_sub_o(tc_sub_o), .tc_sec_o(tc_sec_o),
      .tc_valid_o(tc_valid_o)
   );

   typedef struct packed {
      logic [27:0] s0;  logic [39:0] c0;
      logic [27:0] sa;  logic [39:0] ca;
      logic [27:0] se;  logic [39:0] ce;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{28'd10, 40'd5,             28'd20, 40'd3,             28'd30, 40'd8},
      '{28'd60, 40'd5,             28'd50, 40'd0,             28'd10, 40'd6},
      '{28'd99, 40'h00_FFFF_FFFF,  28'd1,  40'd0,             28'd0,  40'h01_0000_0000},
      '{28'd0,  40'd7,             28'd99, 40'd2,             28'd99, 40'd9},
      '{28'd50, 40'hFF_FFFF_FFFF,  28'd60, 40'd0,             28'd10, 40'd0},
      '{28'd0,  40'd0,             28'd0,  40'h12_3456_7890,  28'd0,  40'h12_3456_7890}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic stage(input logic [27:0] s, input logic [39:0] c);
      wr(5'h10, {4'h0, s});
      wr(5'h14, c[31:0]);
      wr(5'h18, {24'h0, c[39:32]});
   endtask

   task automatic rd_sec(output logic [39:0] s);
      logic [31:0] lo, hi;
      rd(5'h08, lo);
      rd(5'h0C, hi);
      s = {hi[7:0], lo};
   endtask

   task automatic wait_sub(input logic [27:0] v);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (tc_sub_o == v) break;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [39:0] s;
      logic [27:0] sv;
      int          highs;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(5'h00, d);   check("R11 ctrl after reset", d, 32'h0);
      rd(5'h04, d);   check("R11 sub after reset", d, 32'h0);
      rd_sec(s);      check("R11 sec after reset", s, 40'h0);
      rd(5'h1C, d);   check("R7 flags after reset", d, 32'h1);
      check("R9 pps after reset", pps_o, 1'b0);
      check("R10 tc valid after reset", tc_valid_o, 1'b0);

      // R4/R5/R6 vector table, counting stopped
      for (int i = 0; i < NV; i++) begin
         stage(VECS[i].s0, VECS[i].c0);
         wr(5'h00, (32'd3 << 4) | 32'h8);
         @(negedge clk);
         check($sformatf("R4 load sub v%0d", i), tc_sub_o, VECS[i].s0);
         check($sformatf("R4 load sec v%0d", i), tc_sec_o, VECS[i].c0);
         stage(VECS[i].sa, VECS[i].ca);
         wr(5'h00, (32'd3 << 4) | 32'h4);
         rd(5'h00, d);
         check($sformatf("R6 busy v%0d", i), d[2], 1'b1);
         @(negedge clk);
         rd(5'h00, d);
         check($sformatf("R6 done v%0d", i), d[2], 1'b0);
         rd(5'h04, d);
         check($sformatf("R5 sub v%0d", i), d, {4'h0, VECS[i].se});
         rd_sec(s);
         check($sformatf("R5 sec v%0d", i), s, VECS[i].ce);
      end

      // R11 staging and control readback
      rd(5'h10, d); check("R11 stg sub", d, 32'h0);
      rd(5'h14, d); check("R11 stg lo", d, 32'h3456_7890);
      rd(5'h18, d); check("R11 stg hi", d, 32'h12);
      rd(5'h00, d); check("R11 ctrl width", d, 32'h30);

      // R2 stopped counters hold
      sv = tc_sub_o;
      repeat (5) @(negedge clk);
      check("R2 held sub", tc_sub_o, sv);

      // R1 write with clear bit 0 has no effect, then clear
      stage(28'd5, 40'd7);
      wr(5'h00, (32'd3 << 4) | 32'h8);
      wr(5'h00, (32'd3 << 4));
      @(negedge clk);
      check("R1 no clear sub", tc_sub_o, 28'd5);
      check("R1 no clear sec", tc_sec_o, 40'd7);
      wr(5'h00, (32'd3 << 4) | 32'h1);
      @(negedge clk);
      check("R1 cleared sub", tc_sub_o, 28'd0);
      check("R1 cleared sec", tc_sec_o, 40'd0);

      // R3/R9 counting, wrap and pulse
      wr(5'h1C, 32'h2);
      rd(5'h1C, d); check("R11 flags readback", d, 32'h3);
      stage(28'd95, 40'd3);
      wr(5'h00, (32'd3 << 4) | 32'h8);
      wr(5'h00, (32'd3 << 4) | 32'h2);
      wait_sub(28'd0);
      check("R3 wrap sec", tc_sec_o, 40'd4);
      highs = 0;
      for (int i = 0; i < 10; i++) begin
         if (pps_o) highs++;
         @(negedge clk);
      end
      check("R9 pulse width", highs, 3);
      check("R3 counting", tc_sub_o, 28'd10);

      // R10 timecode valid flag
      check("R10 tc valid low", tc_valid_o, 1'b0);
      wr(5'h1C, 32'h4);
      check("R10 tc valid high", tc_valid_o, 1'b1);
      check("R10 tc sec live", tc_sec_o, 40'd4);

      // R9 pulse gated by pps valid flag
      wait_sub(28'd0);
      highs = 0;
      for (int i = 0; i < 10; i++) begin
         if (pps_o) highs++;
         @(negedge clk);
      end
      check("R9 gated pulse", highs, 0);

      // R7 sync handshake
      wr(5'h1C, 32'h7);
      rd(5'h1C, d); check("R7 armed reads 0", d[0], 1'b0);
      wait_sub(28'd20);
      s = tc_sec_o;
      ext_pps_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 not yet", tc_sub_o, 28'd22);
      @(negedge clk);
      check("R7 sub realigned", tc_sub_o, 28'd0);
      check("R7 sec advanced", tc_sec_o, s + 40'd1);
      check("R9 pulse on sync", pps_o, 1'b1);
      rd(5'h1C, d); check("R7 done reads 1", d[0], 1'b1);

      // R8 unarmed edge ignored
      ext_pps_i = 1'b0;
      repeat (3) @(negedge clk);
      sv = tc_sub_o;
      s = tc_sec_o;
      ext_pps_i = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 sub keeps counting", tc_sub_o, sv + 28'd4);
      check("R8 sec unchanged", tc_sec_o, s);
      ext_pps_i = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule